// File: doc/BRIEF.md
# Open-Row Timeout Bank Manager

This block keeps track of the row state of every bank of a DRAM device and turns one pending access request (bank, row, read or write) into the DRAM command sequence it needs. If the requested row is already open, the block issues the column command straight away. If the bank is closed, it activates the row first. If a different row is open, it precharges, activates and then issues the column command. Every command waits until a per-bank legal-to-issue flag, supplied by an external timing checker, allows it.

After a column command the row stays open under an idle counter that is loaded from a configuration input. Each row hit reloads the counter. When the counter runs out, the block asks for a precharge of that bank once the precharge is legal. A configured value of zero turns this into a close-page policy. The block puts out at most one command per cycle. The command for the pending request wins over timeout precharges. Among timeout precharges, the lowest bank goes first.

Top module: `row_keeper`

## Requirements
- R1: While reset is asserted and right after it, `cmd_o` is NOP (code 0) and `req_ready_o` is low, and every bank is closed, so the first request to any bank needs an activate.
- R2: A request to a closed bank first issues ACT (code 1) on `cmd_bank_o` with the requested row on `cmd_row_o`, then the column command for the same bank.
- R3: A request whose row matches the open row of its bank issues RD (code 3) or WR (code 4, when `req_write_i` is high) at once, and `req_ready_o` is high in exactly that cycle.
- R4: A request to a bank whose open row differs issues PRE (code 2) to that bank, then ACT with the new row, then the column command.
- R5: A command for the request is issued only in a cycle where its legal flag for that bank is high: `act_ok_i` for ACT, `pre_ok_i` for PRE and `col_ok_i` for RD/WR. Until then `cmd_o` stays NOP, with no other work available.
- R6: With idle value N and no further traffic, the bank's timeout PRE appears N+1 cycles after the cycle of its last column command.
- R7: A row hit reloads the idle counter, so the PRE comes N+1 cycles after the hit and not after the earlier access.
- R8: With N = 0, the PRE comes in the cycle right after the column command.
- R9: At most one command per cycle. The request's command has priority over timeout precharges, and pending timeout precharges go out lowest bank first.
- R10: A bank whose counter has expired but that is the target of a pending hit issues the column command and not a PRE.
- R11: A timeout PRE that is blocked by a low `pre_ok_i` is held and issued in the first cycle where the flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| row_open_cnt_i | input | CNT_W | Idle cycles a row stays open after a column command |
| req_valid_i | input | 1 | Access request pending, held until accepted |
| req_bank_i | input | BANK_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_ready_o | output | 1 | Column command for the request is issued this cycle |
| act_ok_i | input | NUM_BANKS | Per-bank ACT legal |
| pre_ok_i | input | NUM_BANKS | Per-bank PRE legal |
| col_ok_i | input | NUM_BANKS | Per-bank RD/WR legal |
| cmd_o | output | 3 | Command: 0 NOP, 1 ACT, 2 PRE, 3 RD, 4 WR |
| cmd_bank_o | output | BANK_W | Bank of the command |
| cmd_row_o | output | ROW_W | Row for ACT (open row for PRE) |

## Verification
The bench builds the block with its defaults: 4 banks, 14-bit rows and an 8-bit idle counter. Four banks are enough to line up several expired banks against a live request and to watch the lowest-bank-first order. The idle value is a run-time input, so the bench uses a large value while it walks the hit, closed and conflict sequences, and values of 0, 2 and 3 to place expiry, hits that reload the counter, and a hit exactly at expiry on cycles it can count.

// File: rtl/row_keeper_pkg.sv
package row_keeper_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE,
    BK_ACTIVATING,
    BK_ACTIVE,
    BK_PRECHARGING
  } bank_st_e;
endpackage

// File: rtl/rk_bank.sv
module rk_bank
  import row_keeper_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] idle_cfg_i,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             col_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             act_ok_i,
  output bank_st_e         st_o,
  output logic [ROW_W-1:0] row_o,
  output logic             expired_o
);
  bank_st_e         st_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BK_IDLE;
      row_q <= '0;
      cnt_q <= '0;
    end else if (act_i) begin
      st_q  <= BK_ACTIVATING;
      row_q <= row_i;
    end else if (pre_i) begin
      st_q <= BK_PRECHARGING;
    end else if (col_i) begin
      st_q  <= BK_ACTIVE;
      cnt_q <= idle_cfg_i;
    end else begin
      // tRP done once the checker allows a new ACT
      if (st_q == BK_PRECHARGING && act_ok_i) st_q <= BK_IDLE;
      if (st_q == BK_ACTIVE && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign st_o      = st_q;
  assign row_o     = row_q;
  assign expired_o = (st_q == BK_ACTIVE) && (cnt_q == '0);
endmodule

// File: rtl/rk_pick.sv
module rk_pick
  import row_keeper_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic                 req_valid_i,
  input  cmd_e                 req_cmd_i,
  input  logic                 req_ok_i,
  input  logic [BANK_W-1:0]    req_bank_i,
  input  logic [NUM_BANKS-1:0] expired_i,
  input  logic [NUM_BANKS-1:0] pre_ok_i,
  output cmd_e                 cmd_o,
  output logic [BANK_W-1:0]    bank_o
);
  logic              to_hit;
  logic [BANK_W-1:0] to_bank;

  always_comb begin
    to_hit  = 1'b0;
    to_bank = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      // the requested bank is never closed by timeout
      if (expired_i[b] && pre_ok_i[b] &&
          !(req_valid_i && req_bank_i == BANK_W'(b))) begin
        to_hit  = 1'b1;
        to_bank = BANK_W'(b);
      end
    end
  end

  always_comb begin
    cmd_o  = CMD_NOP;
    bank_o = '0;
    if (req_valid_i && req_ok_i) begin
      cmd_o  = req_cmd_i;
      bank_o = req_bank_i;
    end else if (to_hit) begin
      cmd_o  = CMD_PRE;
      bank_o = to_bank;
    end
  end
endmodule

// File: rtl/row_keeper.sv
module row_keeper
  import row_keeper_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 14,
  parameter int CNT_W     = 8,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CNT_W-1:0]     row_open_cnt_i,
  input  logic                 req_valid_i,
  input  logic [BANK_W-1:0]    req_bank_i,
  input  logic [ROW_W-1:0]     req_row_i,
  input  logic                 req_write_i,
  output logic                 req_ready_o,
  input  logic [NUM_BANKS-1:0] act_ok_i,
  input  logic [NUM_BANKS-1:0] pre_ok_i,
  input  logic [NUM_BANKS-1:0] col_ok_i,
  output logic [2:0]           cmd_o,
  output logic [BANK_W-1:0]    cmd_bank_o,
  output logic [ROW_W-1:0]     cmd_row_o
);
  bank_st_e                 st   [NUM_BANKS];
  logic [ROW_W-1:0]         orow [NUM_BANKS];
  logic [NUM_BANKS-1:0]     expired;
  logic [NUM_BANKS-1:0]     act_v, pre_v, col_v;

  cmd_e              need_cmd, cmd;
  logic              need_ok, is_open, is_hit;
  logic [BANK_W-1:0] cmd_bank;

  always_comb begin
    is_open  = (st[req_bank_i] == BK_ACTIVATING) || (st[req_bank_i] == BK_ACTIVE);
    is_hit   = is_open && (orow[req_bank_i] == req_row_i);
    if (is_hit) begin
      need_cmd = req_write_i ? CMD_WR : CMD_RD;
      need_ok  = col_ok_i[req_bank_i];
    end else if (is_open) begin
      need_cmd = CMD_PRE;
      need_ok  = pre_ok_i[req_bank_i];
    end else begin
      need_cmd = CMD_ACT;
      need_ok  = act_ok_i[req_bank_i];
    end
  end

  rk_pick #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_pick (
    .req_valid_i(req_valid_i),
    .req_cmd_i  (need_cmd),
    .req_ok_i   (need_ok),
    .req_bank_i (req_bank_i),
    .expired_i  (expired),
    .pre_ok_i   (pre_ok_i),
    .cmd_o      (cmd),
    .bank_o     (cmd_bank)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign act_v[b] = (cmd == CMD_ACT) && (cmd_bank == BANK_W'(b));
    assign pre_v[b] = (cmd == CMD_PRE) && (cmd_bank == BANK_W'(b));
    assign col_v[b] = (cmd == CMD_RD || cmd == CMD_WR) && (cmd_bank == BANK_W'(b));

    rk_bank #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .idle_cfg_i(row_open_cnt_i),
      .act_i     (act_v[b]),
      .pre_i     (pre_v[b]),
      .col_i     (col_v[b]),
      .row_i     (req_row_i),
      .act_ok_i  (act_ok_i[b]),
      .st_o      (st[b]),
      .row_o     (orow[b]),
      .expired_o (expired[b])
    );
  end

  assign cmd_o       = cmd;
  assign cmd_bank_o  = cmd_bank;
  assign cmd_row_o   = (cmd == CMD_PRE) ? orow[cmd_bank] :
                       (cmd == CMD_NOP) ? '0 : req_row_i;
  assign req_ready_o = (cmd == CMD_RD) || (cmd == CMD_WR);
endmodule

// File: rtl/row_keeper_chk.sv
module row_keeper_chk
  import row_keeper_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic [BANK_W-1:0]    req_bank_i,
  input logic                 req_write_i,
  input logic                 req_ready_o,
  input logic [NUM_BANKS-1:0] act_ok_i,
  input logic [NUM_BANKS-1:0] pre_ok_i,
  input logic [NUM_BANKS-1:0] col_ok_i,
  input logic [2:0]           cmd_o,
  input logic [BANK_W-1:0]    cmd_bank_o
);
  // R5
  act_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == CMD_ACT |-> act_ok_i[cmd_bank_o]);
  // R5
  pre_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == CMD_PRE |-> pre_ok_i[cmd_bank_o]);
  // R5
  col_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_RD || cmd_o == CMD_WR) |-> col_ok_i[cmd_bank_o]);
  // R3
  ready_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (req_valid_i && cmd_bank_o == req_bank_i &&
                     cmd_o == (req_write_i ? CMD_WR : CMD_RD)));
  // R4
  no_col_after_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == CMD_PRE |=> !((cmd_o == CMD_RD || cmd_o == CMD_WR) &&
                           cmd_bank_o == $past(cmd_bank_o)));
  // R1
  reset_nop_chk: assert property (@(posedge clk_i)
    !rst_ni |-> cmd_o == CMD_NOP);
endmodule

bind row_keeper row_keeper_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_bank_i (req_bank_i),
  .req_write_i(req_write_i),
  .req_ready_o(req_ready_o),
  .act_ok_i   (act_ok_i),
  .pre_ok_i   (pre_ok_i),
  .col_ok_i   (col_ok_i),
  .cmd_o      (cmd_o),
  .cmd_bank_o (cmd_bank_o)
);

// File: tb/row_keeper_test.sv
module row_keeper_test;
  localparam int NB = 4;
  localparam int RW = 14;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [CW-1:0] ocnt = 8'd200;
  logic          req_valid = 1'b0;
  logic [1:0]    req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic          req_write = 1'b0;
  logic          req_ready;
  logic [NB-1:0] act_ok = '1, pre_ok = '1, col_ok = '1;
  logic [2:0]    cmd;
  logic [1:0]    cmd_bank;
  logic [RW-1:0] cmd_row;

  int tests = 0, fails = 0;
  int got_n;
  int got_cmd [4];
  int got_bank [4];
  int got_row [4];

  always #10 clk = ~clk;

  row_keeper #(.NUM_BANKS(NB), .ROW_W(RW), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .row_open_cnt_i(ocnt),
    .req_valid_i(req_valid), .req_bank_i(req_bank), .req_row_i(req_row),
    .req_write_i(req_write), .req_ready_o(req_ready),
    .act_ok_i(act_ok), .pre_ok_i(pre_ok), .col_ok_i(col_ok),
    .cmd_o(cmd), .cmd_bank_o(cmd_bank), .cmd_row_o(cmd_row)
  );

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    req_valid = 1'b0;
    tick();
    tick();
    rst_ni = 1'b1;
    tick();
  endtask

  // drives a request, records commands until the column command is issued
  task automatic run_req(input int b, input int r, input bit w);
    req_bank = 2'(b); req_row = RW'(r); req_write = w; req_valid = 1'b1;
    got_n = 0;
    for (int k = 0; k < 10; k++) begin
      #1;
      if (cmd != 3'd0 && got_n < 4) begin
        got_cmd[got_n] = int'(cmd); got_bank[got_n] = int'(cmd_bank);
        got_row[got_n] = int'(cmd_row); got_n++;
      end
      if (req_ready) break;
      #0 tick();
    end
    tick();
    req_valid = 1'b0;
  endtask

  // expects n-1 NOP cycles then PRE to bank b; starts at current cycle
  task automatic expect_pre_after(input int n, input int b, input string tag);
    for (int k = 1; k < n; k++) begin
      #1; chk(cmd == 3'd0, tag, int'(cmd), 0);
      tick();
    end
    #1;
    chk(cmd == 3'd2 && int'(cmd_bank) == b, tag, int'(cmd) * 10 + int'(cmd_bank), 20 + b);
  endtask

  // {kind[1:0], wr, bank[1:0], row[3:0]}; kind 0 hit, 1 closed, 2 conflict
  localparam logic [8:0] VEC [8] = '{
    {2'd1, 1'b0, 2'd0, 4'd5},
    {2'd0, 1'b1, 2'd0, 4'd5},
    {2'd1, 1'b0, 2'd1, 4'd7},
    {2'd2, 1'b0, 2'd0, 4'd9},
    {2'd0, 1'b1, 2'd1, 4'd7},
    {2'd0, 1'b1, 2'd0, 4'd9},
    {2'd1, 1'b0, 2'd2, 4'd3},
    {2'd2, 1'b0, 2'd1, 4'd2}
  };

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #5;
    #1;
    chk(cmd == 3'd0, "R1 nop in reset", int'(cmd), 0);
    do_reset();
    #1;
    chk(cmd == 3'd0 && !req_ready, "R1 nop after reset", int'(cmd), 0);

    // table walk, large idle value
    for (int v = 0; v < 8; v++) begin
      int kind, b, r, colc, exp_n;
      bit w;
      kind = int'(VEC[v][8:7]); w = VEC[v][6];
      b = int'(VEC[v][5:4]); r = int'(VEC[v][3:0]);
      colc = w ? 4 : 3;
      exp_n = kind + 1;
      run_req(b, r, w);
      chk(got_n == exp_n, "R2/R3/R4 command count", got_n, exp_n);
      if (got_n == exp_n) begin
        for (int k = 0; k < got_n; k++)
          chk(got_bank[k] == b, "R2/R3/R4 command bank", got_bank[k], b);
        chk(got_cmd[got_n-1] == colc, "R3 column command", got_cmd[got_n-1], colc);
        if (kind == 2) chk(got_cmd[0] == 2, "R4 pre first", got_cmd[0], 2);
        if (kind >= 1) begin
          chk(got_cmd[kind-1] == 1, "R2 act before column", got_cmd[kind-1], 1);
          chk(got_row[kind-1] == r, "R2 act row", got_row[kind-1], r);
        end
      end
    end

    // R5: act held while illegal
    do_reset();
    act_ok = '0;
    req_bank = 2'd3; req_row = 14'd11; req_write = 1'b0; req_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1; chk(cmd == 3'd0 && !req_ready, "R5 act held", int'(cmd), 0);
      tick();
    end
    act_ok = '1;
    #1; chk(cmd == 3'd1 && cmd_bank == 2'd3, "R5 act once legal", int'(cmd), 1);
    col_ok = '0;
    tick();
    #1; chk(cmd == 3'd0, "R5 column held", int'(cmd), 0);
    col_ok = '1;
    #1; chk(cmd == 3'd3 && req_ready, "R5 column once legal", int'(cmd), 3);
    tick();
    req_valid = 1'b0;

    // R6: idle timeout N=3
    do_reset();
    ocnt = 8'd3;
    run_req(0, 1, 1'b0);
    expect_pre_after(4, 0, "R6 timeout pre");

    // R7: hit reloads counter
    do_reset();
    run_req(0, 1, 1'b0);
    #1; chk(cmd == 3'd0, "R7 idle", int'(cmd), 0);
    tick();
    run_req(0, 1, 1'b1);
    chk(got_n == 1 && got_cmd[0] == 4, "R7 hit write", got_cmd[0], 4);
    expect_pre_after(4, 0, "R7 reloaded timeout");

    // R10: hit exactly at expiry, N=2
    do_reset();
    ocnt = 8'd2;
    run_req(1, 6, 1'b0);
    tick();
    tick();
    run_req(1, 6, 1'b0);
    chk(got_n == 1 && got_cmd[0] == 3, "R10 hit beats expiry", got_cmd[0], 3);
    expect_pre_after(3, 1, "R10 timeout after hit");

    // R8: close page
    do_reset();
    ocnt = 8'd0;
    run_req(2, 8, 1'b0);
    expect_pre_after(1, 2, "R8 close page pre");

    // R11: timeout pre held by pre_ok
    do_reset();
    pre_ok = '0;
    run_req(2, 8, 1'b0);
    for (int k = 0; k < 2; k++) begin
      #1; chk(cmd == 3'd0, "R11 pre held", int'(cmd), 0);
      tick();
    end
    pre_ok = '1;
    #1; chk(cmd == 3'd2 && cmd_bank == 2'd2, "R11 pre once legal", int'(cmd), 2);

    // R9: request priority, then lowest bank first
    do_reset();
    pre_ok = '0;
    run_req(3, 1, 1'b0);
    run_req(1, 1, 1'b0);
    pre_ok = '1;
    run_req(2, 4, 1'b0);
    chk(got_n == 2 && got_cmd[0] == 1 && got_cmd[1] == 3, "R9 request first",
        got_n, 2);
    expect_pre_after(1, 1, "R9 lowest bank pre");
    tick();
    expect_pre_after(1, 2, "R9 second pre");
    tick();
    expect_pre_after(1, 3, "R9 third pre");
    tick();
    #1; chk(cmd == 3'd0, "R9 quiet after", int'(cmd), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule